// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

The block keeps the receive and transmit statistics of one Ethernet MAC. At the end of every frame the MAC hands it one event for each direction it finished. An event carries the frame length in bytes, the error flags found upstream, and the address class of the frame (multicast, broadcast, pause). The block bumps the frame count and the byte count. It also bumps one of seven frame-size bins and every flag counter whose flag is set. Receive frames are tested against two length limits: the standard 1518-byte limit and a programmed maximum. Each limit has its own counter.

A host reads the counters through a simple read port. Every read clears the counter it returns, so software gathers deltas and adds them up itself. An increment that lands in the same cycle as a clearing read is not lost. The two byte counters are wider than the read word, so each is read as a low word followed by a high word. Reading the low word captures the upper part into a snapshot, which the high-word read then returns. A global clear input zeroes the whole bank at once.

Top module: `mac_stat_bank`

## Requirements
- R1: A receive event (`rx_valid` high) adds 1 to the receive frame count and adds `rx_len` to the receive byte count. A transmit event does the same on the transmit side with `tx_len`.
- R2: Each event adds 1 to exactly one size bin of its direction. Bin 0 takes lengths up to 64, including runts. The other bins are 1: 65–127, 2: 128–255, 3: 256–511, 4: 512–1023, 5: 1024–1518 and 6: 1519 and longer.
- R3: Each flag of an event adds 1 to its own counter. On receive the flags are multicast, broadcast, pause, FCS error, jabber, short and symbol error. On transmit they are multicast, broadcast, pause and error. Flags presented while the event's valid is low have no effect.
- R4: A receive frame with `rx_len` greater than 1518 counts as oversize. A receive frame with `rx_len` greater than `cfg_max_len` counts as over-maximum. The two counters are separate and each is bumped independently of the other.
- R5: A read with `rd_en` high returns data on `rd_data` after the next clock edge. `rd_data` holds between reads. The address map is:
  - 0 and 1: receive bytes, low and high words.
  - 2 and 3: transmit bytes, low and high words.
  - 4 to 20: receive frames, multicast, broadcast, pause, FCS error, jabber, short, symbol error, oversize, over-maximum, then bins 0 to 6.
  - 21 to 32: transmit frames, multicast, broadcast, pause, error, then bins 0 to 6.
  - Any other address returns 0 and clears nothing.
- R6: Reading a frame counter or a low byte word clears that counter. If an increment arrives in the same cycle as the read, the counter restarts at that increment: 1 for a frame counter, the frame length for a byte counter.
- R7: Reading a low byte word copies the upper part of that counter (the bits above the read word) into a snapshot. A high-word read returns this snapshot and clears neither the snapshot nor the counter.
- R8: `clr_all` zeroes every counter and both snapshots on the next edge, and any events in that cycle are dropped. A read issued in the same cycle returns the value from before the clear.
- R9: Frame counters wrap modulo 2^FRM_W and byte counters wrap modulo 2^BYTE_W.
- R10: After reset, every counter and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_all | input | 1 | Zero every counter and snapshot |
| cfg_max_len | input | LEN_W | Programmed maximum receive length |
| rx_valid | input | 1 | Receive end-of-frame event |
| rx_len | input | LEN_W | Receive frame length in bytes |
| rx_mcast | input | 1 | Receive frame is multicast |
| rx_bcast | input | 1 | Receive frame is broadcast |
| rx_pause | input | 1 | Receive frame is a pause frame |
| rx_fcs_err | input | 1 | Receive FCS error |
| rx_jabber | input | 1 | Receive jabber |
| rx_short | input | 1 | Receive short frame |
| rx_sym_err | input | 1 | Receive symbol-code error |
| tx_valid | input | 1 | Transmit end-of-frame event |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| tx_mcast | input | 1 | Transmit frame is multicast |
| tx_bcast | input | 1 | Transmit frame is broadcast |
| tx_pause | input | 1 | Transmit frame is a pause frame |
| tx_err | input | 1 | Transmit error (bad FCS, underrun and similar) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | WORD_W | Read data, one cycle after the strobe |

## Verification
The hardest situations to reach from the ports are a non-zero high byte word and the wrap of a counter. At the default widths both need billions of frames. The bench therefore builds the block with narrower frame counters, read word and byte counters. With those widths a few long frames carry the byte count past the low word, and about a thousand events wrap both kinds of counter. A clearing read is also placed in the same cycle as an event, and events are sent between a low read and its high read. This shows that the count restarts at the increment while the high word still returns the snapshot.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;

    // Narrow counter indices (address = ADDR_NARROW0 + index)
    localparam int IX_RX_FRAMES  = 0;
    localparam int IX_RX_MCAST   = 1;
    localparam int IX_RX_BCAST   = 2;
    localparam int IX_RX_PAUSE   = 3;
    localparam int IX_RX_FCS     = 4;
    localparam int IX_RX_JABBER  = 5;
    localparam int IX_RX_SHORT   = 6;
    localparam int IX_RX_SYMERR  = 7;
    localparam int IX_RX_OVERSZ  = 8;
    localparam int IX_RX_OVERMAX = 9;
    localparam int IX_RX_BIN0    = 10;
    localparam int NUM_BINS      = 7;
    localparam int IX_TX_FRAMES  = IX_RX_BIN0 + NUM_BINS;
    localparam int IX_TX_MCAST   = IX_TX_FRAMES + 1;
    localparam int IX_TX_BCAST   = IX_TX_FRAMES + 2;
    localparam int IX_TX_PAUSE   = IX_TX_FRAMES + 3;
    localparam int IX_TX_ERR     = IX_TX_FRAMES + 4;
    localparam int IX_TX_BIN0    = IX_TX_FRAMES + 5;
    localparam int NUM_NARROW    = IX_TX_BIN0 + NUM_BINS;
    localparam int NARROW_IW     = $clog2(NUM_NARROW);

    localparam int ADDR_RXB_LO   = 0;
    localparam int ADDR_RXB_HI   = 1;
    localparam int ADDR_TXB_LO   = 2;
    localparam int ADDR_TXB_HI   = 3;
    localparam int ADDR_NARROW0  = 4;
    localparam int ADDR_END      = ADDR_NARROW0 + NUM_NARROW;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_NARROW,
        SEL_WIDE_LO,
        SEL_WIDE_HI
    } rd_sel_e;

    typedef struct packed {
        rd_sel_e              sel;
        logic                 wide_tx;
        logic [NARROW_IW-1:0] idx;
    } rd_dec_t;

    typedef struct packed {
        logic mcast;
        logic bcast;
        logic pause;
    } frm_class_t;

    typedef struct packed {
        logic fcs;
        logic jabber;
        logic runt;
        logic sym;
    } rx_fault_t;

    // Upper edges of bins 0..5; bin 6 takes everything above the last edge
    function automatic int unsigned size_bin(input int unsigned len);
        int unsigned b;
        if      (len <= 64)   b = 0;
        else if (len <= 127)  b = 1;
        else if (len <= 255)  b = 2;
        else if (len <= 511)  b = 3;
        else if (len <= 1023) b = 4;
        else if (len <= 1518) b = 5;
        else                  b = 6;
        return b;
    endfunction

    function automatic rd_dec_t decode_addr(input int unsigned addr);
        rd_dec_t d;
        d.sel     = SEL_NONE;
        d.wide_tx = 1'b0;
        d.idx     = '0;
        if (addr == ADDR_RXB_LO || addr == ADDR_TXB_LO) begin
            d.sel     = SEL_WIDE_LO;
            d.wide_tx = (addr == ADDR_TXB_LO);
        end else if (addr == ADDR_RXB_HI || addr == ADDR_TXB_HI) begin
            d.sel     = SEL_WIDE_HI;
            d.wide_tx = (addr == ADDR_TXB_HI);
        end else if (addr >= ADDR_NARROW0 && addr < ADDR_END) begin
            d.sel = SEL_NARROW;
            d.idx = NARROW_IW'(addr - ADDR_NARROW0);
        end
        return d;
    endfunction

endpackage

// File: rtl/stat_event_decode.sv
module stat_event_decode
    import mac_stat_pkg::*;
#(
    parameter int LEN_W   = 14,
    parameter int STD_MAX = 1518
) (
    input  logic                  rx_valid,
    input  logic [LEN_W-1:0]      rx_len,
    input  frm_class_t            rx_cls,
    input  rx_fault_t             rx_flt,
    input  logic [LEN_W-1:0]      cfg_max_len,
    input  logic                  tx_valid,
    input  logic [LEN_W-1:0]      tx_len,
    input  frm_class_t            tx_cls,
    input  logic                  tx_err,
    output logic [NUM_NARROW-1:0] inc,
    output logic [LEN_W-1:0]      rx_add,
    output logic [LEN_W-1:0]      tx_add
);

    int unsigned rx_bin;
    int unsigned tx_bin;

    always_comb begin
        rx_bin = size_bin(32'(rx_len));
        tx_bin = size_bin(32'(tx_len));
        inc    = '0;
        if (rx_valid) begin
            inc[IX_RX_FRAMES]       = 1'b1;
            inc[IX_RX_MCAST]        = rx_cls.mcast;
            inc[IX_RX_BCAST]        = rx_cls.bcast;
            inc[IX_RX_PAUSE]        = rx_cls.pause;
            inc[IX_RX_FCS]          = rx_flt.fcs;
            inc[IX_RX_JABBER]       = rx_flt.jabber;
            inc[IX_RX_SHORT]        = rx_flt.runt;
            inc[IX_RX_SYMERR]       = rx_flt.sym;
            inc[IX_RX_OVERSZ]       = (32'(rx_len) > STD_MAX);
            inc[IX_RX_OVERMAX]      = (rx_len > cfg_max_len);
            inc[IX_RX_BIN0 + rx_bin] = 1'b1;
        end
        if (tx_valid) begin
            inc[IX_TX_FRAMES]       = 1'b1;
            inc[IX_TX_MCAST]        = tx_cls.mcast;
            inc[IX_TX_BCAST]        = tx_cls.bcast;
            inc[IX_TX_PAUSE]        = tx_cls.pause;
            inc[IX_TX_ERR]          = tx_err;
            inc[IX_TX_BIN0 + tx_bin] = 1'b1;
        end
        rx_add = rx_valid ? rx_len : '0;
        tx_add = tx_valid ? tx_len : '0;
    end

endmodule

// File: rtl/stat_narrow_ctr.sv
module stat_narrow_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_all,
    input  logic         rd_clr,
    input  logic         inc,
    output logic [W-1:0] cnt_q
);

    logic [W-1:0] inc_w;
    assign inc_w = {{(W-1){1'b0}}, inc};

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            cnt_q <= '0;
        end else if (rd_clr) begin
            cnt_q <= inc_w;
        end else begin
            cnt_q <= cnt_q + inc_w;
        end
    end

endmodule

// File: rtl/stat_wide_ctr.sv
module stat_wide_ctr #(
    parameter int BYTE_W = 45,
    parameter int WORD_W = 32,
    parameter int LEN_W  = 14,
    localparam int HI_W  = BYTE_W - WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_all,
    input  logic              rd_lo,
    input  logic [LEN_W-1:0]  add,
    output logic [BYTE_W-1:0] cnt_q,
    output logic [HI_W-1:0]   snap_q
);

    logic [BYTE_W-1:0] add_w;
    assign add_w = BYTE_W'(add);

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            cnt_q  <= '0;
            snap_q <= '0;
        end else if (rd_lo) begin
            cnt_q  <= add_w;
            snap_q <= cnt_q[BYTE_W-1:WORD_W];
        end else begin
            cnt_q  <= cnt_q + add_w;
        end
    end

endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
    import mac_stat_pkg::*;
#(
    parameter int LEN_W   = 14,
    parameter int FRM_W   = 32,
    parameter int BYTE_W  = 45,
    parameter int WORD_W  = 32,
    parameter int STD_MAX = 1518,
    parameter int ADDR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_all,
    input  logic [LEN_W-1:0]  cfg_max_len,
    input  logic              rx_valid,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              rx_mcast,
    input  logic              rx_bcast,
    input  logic              rx_pause,
    input  logic              rx_fcs_err,
    input  logic              rx_jabber,
    input  logic              rx_short,
    input  logic              rx_sym_err,
    input  logic              tx_valid,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic              tx_mcast,
    input  logic              tx_bcast,
    input  logic              tx_pause,
    input  logic              tx_err,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    localparam int HI_W = BYTE_W - WORD_W;

    frm_class_t                        rx_cls;
    frm_class_t                        tx_cls;
    rx_fault_t                         rx_flt;
    logic [NUM_NARROW-1:0]             inc;
    logic [LEN_W-1:0]                  rx_add;
    logic [LEN_W-1:0]                  tx_add;
    rd_dec_t                           dec;
    logic [NUM_NARROW-1:0][FRM_W-1:0]  narrow_q;
    logic [BYTE_W-1:0]                 rx_bytes_q;
    logic [BYTE_W-1:0]                 tx_bytes_q;
    logic [HI_W-1:0]                   rx_snap_q;
    logic [HI_W-1:0]                   tx_snap_q;
    logic                              rx_rd_lo;
    logic                              tx_rd_lo;
    logic [WORD_W-1:0]                 rd_next;

    assign rx_cls = '{mcast: rx_mcast, bcast: rx_bcast, pause: rx_pause};
    assign tx_cls = '{mcast: tx_mcast, bcast: tx_bcast, pause: tx_pause};
    assign rx_flt = '{fcs: rx_fcs_err, jabber: rx_jabber, runt: rx_short, sym: rx_sym_err};

    stat_event_decode #(
        .LEN_W  (LEN_W),
        .STD_MAX(STD_MAX)
    ) u_decode (
        .rx_valid   (rx_valid),
        .rx_len     (rx_len),
        .rx_cls     (rx_cls),
        .rx_flt     (rx_flt),
        .cfg_max_len(cfg_max_len),
        .tx_valid   (tx_valid),
        .tx_len     (tx_len),
        .tx_cls     (tx_cls),
        .tx_err     (tx_err),
        .inc        (inc),
        .rx_add     (rx_add),
        .tx_add     (tx_add)
    );

    assign dec = decode_addr(32'(rd_addr));

    for (genvar k = 0; k < NUM_NARROW; k++) begin : g_narrow
        logic rd_clr;
        assign rd_clr = rd_en && (dec.sel == SEL_NARROW) && (dec.idx == NARROW_IW'(k));
        stat_narrow_ctr #(.W(FRM_W)) u_ctr (
            .clk    (clk),
            .rst    (rst),
            .clr_all(clr_all),
            .rd_clr (rd_clr),
            .inc    (inc[k]),
            .cnt_q  (narrow_q[k])
        );
    end

    assign rx_rd_lo = rd_en && (dec.sel == SEL_WIDE_LO) && !dec.wide_tx;
    assign tx_rd_lo = rd_en && (dec.sel == SEL_WIDE_LO) &&  dec.wide_tx;

    stat_wide_ctr #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .LEN_W(LEN_W)) u_rx_bytes (
        .clk    (clk),
        .rst    (rst),
        .clr_all(clr_all),
        .rd_lo  (rx_rd_lo),
        .add    (rx_add),
        .cnt_q  (rx_bytes_q),
        .snap_q (rx_snap_q)
    );

    stat_wide_ctr #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .LEN_W(LEN_W)) u_tx_bytes (
        .clk    (clk),
        .rst    (rst),
        .clr_all(clr_all),
        .rd_lo  (tx_rd_lo),
        .add    (tx_add),
        .cnt_q  (tx_bytes_q),
        .snap_q (tx_snap_q)
    );

    always_comb begin
        rd_next = '0;
        case (dec.sel)
            SEL_NARROW:  rd_next = WORD_W'(narrow_q[dec.idx]);
            SEL_WIDE_LO: rd_next = dec.wide_tx ? tx_bytes_q[WORD_W-1:0] : rx_bytes_q[WORD_W-1:0];
            SEL_WIDE_HI: rd_next = dec.wide_tx ? WORD_W'(tx_snap_q) : WORD_W'(rx_snap_q);
            default:     rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_next;
        end
    end

endmodule

module mac_stat_bank_chk
    import mac_stat_pkg::*;
#(
    parameter int LEN_W   = 14,
    parameter int FRM_W   = 32,
    parameter int BYTE_W  = 45,
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = 6
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             clr_all,
    input logic [LEN_W-1:0]                 cfg_max_len,
    input logic                             rx_valid,
    input logic [LEN_W-1:0]                 rx_len,
    input logic                             rd_en,
    input logic [ADDR_W-1:0]                rd_addr,
    input logic [WORD_W-1:0]                rd_data,
    input logic [NUM_NARROW-1:0][FRM_W-1:0] narrow_q,
    input logic [BYTE_W-1:0]                rx_bytes_q,
    input logic [BYTE_W-1:0]                tx_bytes_q,
    input logic [BYTE_W-WORD_W-1:0]         rx_snap_q
);

    localparam logic [ADDR_W-1:0] A_RXF   = ADDR_W'(ADDR_NARROW0 + IX_RX_FRAMES);
    localparam logic [ADDR_W-1:0] A_OMAX  = ADDR_W'(ADDR_NARROW0 + IX_RX_OVERMAX);
    localparam logic [ADDR_W-1:0] A_RXLO  = ADDR_W'(ADDR_RXB_LO);
    localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(ADDR_END);

    // R1: receive frame count steps by one per event
    a_r1_rx_frame_step: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !clr_all && !(rd_en && rd_addr == A_RXF)
        |=> narrow_q[IX_RX_FRAMES] == $past(narrow_q[IX_RX_FRAMES]) + FRM_W'(1));

    // R4: over-maximum counter follows the programmed limit
    a_r4_over_max_step: assert property (@(posedge clk) disable iff (rst)
        rx_valid && (rx_len > cfg_max_len) && !clr_all && !(rd_en && rd_addr == A_OMAX)
        |=> narrow_q[IX_RX_OVERMAX] == $past(narrow_q[IX_RX_OVERMAX]) + FRM_W'(1));

    // R5: unmapped reads return zero
    a_r5_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        rd_en && (rd_addr >= A_END) |=> rd_data == '0);

    // R5: a counter read returns its pre-edge value
    a_r5_read_value: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_addr == A_RXF |=> rd_data == WORD_W'($past(narrow_q[IX_RX_FRAMES])));

    // R6: a clearing read keeps a same-cycle increment
    a_r6_read_clear: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_addr == A_RXF && !clr_all
        |=> narrow_q[IX_RX_FRAMES] == FRM_W'($past(rx_valid)));

    // R7: low-word read captures the upper byte bits
    a_r7_snapshot: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_addr == A_RXLO && !clr_all
        |=> rx_snap_q == $past(rx_bytes_q[BYTE_W-1:WORD_W]));

    // R8: global clear empties the bank
    a_r8_clear_all: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (narrow_q == '0) && (rx_bytes_q == '0) && (tx_bytes_q == '0) && (rx_snap_q == '0));

endmodule

bind mac_stat_bank mac_stat_bank_chk #(
    .LEN_W (LEN_W),
    .FRM_W (FRM_W),
    .BYTE_W(BYTE_W),
    .WORD_W(WORD_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_all    (clr_all),
    .cfg_max_len(cfg_max_len),
    .rx_valid   (rx_valid),
    .rx_len     (rx_len),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .narrow_q   (narrow_q),
    .rx_bytes_q (rx_bytes_q),
    .tx_bytes_q (tx_bytes_q),
    .rx_snap_q  (rx_snap_q)
);

// File: tb/test_mac_stat_bank.sv
module test_mac_stat_bank;

    localparam int LEN_W  = 14;
    localparam int FRM_W  = 8;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 24;
    localparam int ADDR_W = 6;
    localparam int NNAR   = 29;

    localparam longint FMASK = (64'd1 << FRM_W) - 1;
    localparam longint BMASK = (64'd1 << BYTE_W) - 1;
    localparam longint WMASK = (64'd1 << WORD_W) - 1;

    logic              clk = 1'b0;
    logic              rst;
    logic              clr_all;
    logic [LEN_W-1:0]  cfg_max_len;
    logic              rx_valid, rx_mcast, rx_bcast, rx_pause, rx_fcs_err, rx_jabber, rx_short, rx_sym_err;
    logic [LEN_W-1:0]  rx_len;
    logic              tx_valid, tx_mcast, tx_bcast, tx_pause, tx_err;
    logic [LEN_W-1:0]  tx_len;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_data;

    always #10 clk = ~clk;

    mac_stat_bank #(
        .LEN_W(LEN_W), .FRM_W(FRM_W), .BYTE_W(BYTE_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
    ) i_mac_stat_bank (
        .clk(clk), .rst(rst), .clr_all(clr_all), .cfg_max_len(cfg_max_len),
        .rx_valid(rx_valid), .rx_len(rx_len), .rx_mcast(rx_mcast), .rx_bcast(rx_bcast),
        .rx_pause(rx_pause), .rx_fcs_err(rx_fcs_err), .rx_jabber(rx_jabber),
        .rx_short(rx_short), .rx_sym_err(rx_sym_err),
        .tx_valid(tx_valid), .tx_len(tx_len), .tx_mcast(tx_mcast), .tx_bcast(tx_bcast),
        .tx_pause(tx_pause), .tx_err(tx_err),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // ---------------- reference model ----------------
    longint m_cnt [NNAR];
    longint m_inc [NNAR];
    longint m_rxb, m_txb, m_rxs, m_txs, m_rd;
    int     checks = 0;
    int     fails  = 0;
    bit     started = 0;
    bit     done = 0;
    string  cur_req = "R10";

    function automatic int bin_of(input int len);
        if (len <= 64)   return 0;
        if (len <= 127)  return 1;
        if (len <= 255)  return 2;
        if (len <= 511)  return 3;
        if (len <= 1023) return 4;
        if (len <= 1518) return 5;
        return 6;
    endfunction

    function automatic longint read_val(input int a);
        if (a == 0) return m_rxb & WMASK;
        if (a == 1) return m_rxs;
        if (a == 2) return m_txb & WMASK;
        if (a == 3) return m_txs;
        if (a >= 4 && a < 4 + NNAR) return m_cnt[a-4];
        return 0;
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            for (int k = 0; k < NNAR; k++) m_cnt[k] = 0;
            m_rxb = 0; m_txb = 0; m_rxs = 0; m_txs = 0; m_rd = 0;
        end else begin
            for (int k = 0; k < NNAR; k++) m_inc[k] = 0;
            if (rx_valid) begin
                m_inc[0] = 1;
                m_inc[1] = rx_mcast; m_inc[2] = rx_bcast; m_inc[3] = rx_pause;
                m_inc[4] = rx_fcs_err; m_inc[5] = rx_jabber; m_inc[6] = rx_short;
                m_inc[7] = rx_sym_err;
                m_inc[8] = (int'(rx_len) > 1518);
                m_inc[9] = (rx_len > cfg_max_len);
                m_inc[10 + bin_of(int'(rx_len))] = 1;
            end
            if (tx_valid) begin
                m_inc[17] = 1;
                m_inc[18] = tx_mcast; m_inc[19] = tx_bcast; m_inc[20] = tx_pause;
                m_inc[21] = tx_err;
                m_inc[22 + bin_of(int'(tx_len))] = 1;
            end
            if (rd_en) m_rd = read_val(int'(rd_addr));
            if (clr_all) begin
                for (int k = 0; k < NNAR; k++) m_cnt[k] = 0;
                m_rxb = 0; m_txb = 0; m_rxs = 0; m_txs = 0;
            end else begin
                for (int k = 0; k < NNAR; k++) begin
                    longint base;
                    base = (rd_en && int'(rd_addr) == 4 + k) ? 0 : m_cnt[k];
                    m_cnt[k] = (base + m_inc[k]) & FMASK;
                end
                if (rd_en && rd_addr == 0) begin
                    m_rxs = m_rxb >> WORD_W;
                    m_rxb = rx_valid ? longint'(rx_len) : 0;
                end else begin
                    m_rxb = (m_rxb + (rx_valid ? longint'(rx_len) : 0)) & BMASK;
                end
                if (rd_en && rd_addr == 2) begin
                    m_txs = m_txb >> WORD_W;
                    m_txb = tx_valid ? longint'(tx_len) : 0;
                end else begin
                    m_txb = (m_txb + (tx_valid ? longint'(tx_len) : 0)) & BMASK;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (rd_data !== WORD_W'(m_rd)) begin
                fails++;
                $display("FAIL %s rd_data actual=%0d expected=%0d at %0t", cur_req, rd_data, m_rd, $time);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle();
        clr_all = 0; rd_en = 0; rd_addr = '0;
        rx_valid = 0; rx_len = '0; rx_mcast = 0; rx_bcast = 0; rx_pause = 0;
        rx_fcs_err = 0; rx_jabber = 0; rx_short = 0; rx_sym_err = 0;
        tx_valid = 0; tx_len = '0; tx_mcast = 0; tx_bcast = 0; tx_pause = 0; tx_err = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic set_rx(input int len, input logic [6:0] fl);
        rx_valid = 1; rx_len = LEN_W'(len);
        {rx_mcast, rx_bcast, rx_pause, rx_fcs_err, rx_jabber, rx_short, rx_sym_err} = fl;
    endtask

    task automatic set_tx(input int len, input logic [3:0] fl);
        tx_valid = 1; tx_len = LEN_W'(len);
        {tx_mcast, tx_bcast, tx_pause, tx_err} = fl;
    endtask

    task automatic set_rd(input int a);
        rd_en = 1; rd_addr = ADDR_W'(a);
    endtask

    task automatic read_all();
        for (int a = 0; a < 34; a++) begin
            set_rd(a); tick();
        end
        tick();
    endtask

    int lens [16] = '{64, 60, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519, 1600, 1601, 9000};

    initial begin
        idle();
        rst = 1; cfg_max_len = LEN_W'(1600);
        repeat (3) @(negedge clk);
        rst = 0;

        cur_req = "R10"; read_all();                        // reset state

        cur_req = "R2";                                     // size bins, both directions
        for (int i = 0; i < 16; i++) begin
            set_rx(lens[i], 7'd0); set_tx(lens[15-i], 4'd0); tick();
        end
        read_all();

        cur_req = "R4";                                     // oversize vs programmed max
        for (int i = 11; i < 16; i++) begin
            set_rx(lens[i], 7'd0); tick();
        end
        cfg_max_len = LEN_W'(100);
        set_rx(200, 7'd0); tick();
        set_rx(100, 7'd0); tick();
        cfg_max_len = LEN_W'(1600);
        for (int a = 12; a < 14; a++) begin set_rd(a); tick(); end
        tick();

        cur_req = "R3";                                     // flag counters
        for (int i = 0; i < 7; i++) begin
            set_rx(100 + i, 7'(1 << i)); set_tx(70 + i, 4'(1 << (i % 4))); tick();
        end
        set_rx(90, 7'h7f); set_tx(90, 4'hf); tick();
        // flags with valid low must do nothing
        {rx_mcast, rx_bcast, rx_pause, rx_fcs_err, rx_jabber, rx_short, rx_sym_err} = 7'h7f;
        {tx_mcast, tx_bcast, tx_pause, tx_err} = 4'hf; rx_len = 14'd2000; tx_len = 14'd2000;
        tick();
        read_all();

        cur_req = "R1";                                     // frame and byte totals
        for (int i = 0; i < 6; i++) begin
            set_rx(300 + 37 * i, 7'd0); if (i % 2 == 0) set_tx(800 + i, 4'd0); tick();
        end
        set_rd(0); tick(); set_rd(1); tick(); set_rd(2); tick(); set_rd(3); tick();
        set_rd(4); tick(); set_rd(21); tick(); tick();

        cur_req = "R6";                                     // clearing read with same-cycle event
        set_rx(200, 7'b1000000); tick();
        set_rx(333, 7'b1000000); set_rd(4); tick();
        set_rd(4); tick();
        set_rx(500, 7'd0); set_rd(0); tick();
        set_rd(0); tick();
        set_tx(77, 4'b0001); set_rd(25); tick();
        set_rd(25); tick(); tick();

        cur_req = "R7";                                     // snapshot of upper byte bits
        for (int i = 0; i < 5; i++) begin set_rx(16000, 7'd0); set_tx(15000, 4'd0); tick(); end
        set_rd(0); tick();
        set_rx(16000, 7'd0); tick();
        set_rx(16000, 7'd0); tick();
        set_rd(1); tick(); set_rd(1); tick();
        set_rd(2); set_tx(1000, 4'd0); tick(); set_rd(3); tick();
        set_rd(0); tick(); set_rd(1); tick(); tick();

        cur_req = "R8";                                     // global clear
        for (int i = 0; i < 4; i++) begin set_rx(700, 7'h7f); set_tx(1600, 4'hf); tick(); end
        set_rx(400, 7'h7f); set_tx(400, 4'hf); clr_all = 1; set_rd(4); tick();
        set_rd(0); tick(); set_rd(1); tick();
        read_all();

        cur_req = "R9";                                     // wrap of both counter kinds
        for (int i = 0; i < 1100; i++) begin set_rx(16383, 7'b0000010); tick(); end
        set_rd(0); tick(); set_rd(1); tick(); set_rd(4); tick(); set_rd(10); tick(); set_rd(20); tick();
        tick();

        cur_req = "R5";                                     // unmapped and hold
        set_rx(100, 7'd0); tick();
        set_rd(33); tick(); set_rd(40); tick(); set_rd(63); tick();
        repeat (3) tick();
        set_rd(4); tick(); repeat (3) tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog %s actual=timeout expected=completion", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule